// File: doc/BRIEF.md
# Write-Only Clock Configuration Bus Slave

This block is a two-wire bus slave receiver that fills a small bank of clock-control registers. A fast system clock oversamples the SCL and SDA lines. The block detects start and stop conditions and compares the first byte of each transfer against a fixed 7-bit device address with the write direction. When the address matches, the block acknowledges by pulling SDA low during the ninth clock pulse of each byte.

After the address, the master must send two preamble bytes: a command byte and a count byte. The slave acknowledges both and discards their values. Every later byte lands in the next control register, starting at register 0. The slave cannot be read and has no sub-addressing, so changing register k means resending registers 0 to k-1 as well. The register contents drive the per-clock enable bits and the test-mode bit. Two bits of register 3 form the spread-amount selector.

A repeated start begins a new address phase and moves the write pointer back to register 0. A stop in the middle of a byte leaves every register unchanged.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, every control register holds 0xFF, so `ctrl_o` is all ones and `spread_sel_o` is 2'b11. The SDA pull-down is released (`sda_pull_n` = 1).
- R2: A start (SDA falls while SCL is high) followed by the byte 0xD2 (address 1101001 with write bit 0, MSB first) is acknowledged: SDA is held low while SCL is high on the ninth pulse.
- R3: When the first byte after a start is any other address, or has the read bit (0xD3), it is not acknowledged. No later byte is acknowledged and no register changes until the next start.
- R4: The two bytes that follow an accepted address are acknowledged, and their values change no register.
- R5: The third and later bytes after the address are written in order into register 0, 1, 2 and 3. Register n appears on `ctrl_o[8n+7:8n]`.
- R6: Data bytes sent after register 3 has been written are acknowledged and discarded.
- R7: `spread_sel_o` equals bits 6 and 5 of register 3, with bit 6 as the upper bit.
- R8: A register is written only after all eight bits of its byte have arrived. If a stop ends a partial byte, every register keeps its value.
- R9: A repeated start in the middle of a transfer restarts the address phase. The data that follows goes to register 0 again.
- R10: The slave drives SDA only during acknowledge slots. The master's data bits reach the bus unaltered, and SDA is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_pull_n | output | 1 | Open-drain control: 0 pulls SDA low, 1 releases it |
| ctrl_o | output | NUM_REGS*8 | Control registers, register 0 in the low byte |
| spread_sel_o | output | 2 | Spread-amount select taken from register 3 bits 6:5 |

## Verification
The assertions assume that SCL and SDA stay stable for several system clocks after each change. They also assume that SDA changes while SCL is high only to signal a start or a stop, so that a falling SCL edge is never seen together with a start or a stop. The bench's master holds each quarter of a bit period for ten system clocks. It changes SDA only while SCL is low, except during deliberate start and stop sequences, and it releases SDA during every acknowledge slot. Only one master drives the bus, and the slave never stretches the clock.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'b1101001,
  parameter int         NUM_REGS   = 4,
  parameter logic [7:0] REG_INIT   = 8'hFF,
  parameter int         SPREAD_REG = 3,
  parameter int         SPREAD_LSB = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_n,
  output logic [NUM_REGS*8-1:0] ctrl_o,
  output logic [1:0]            spread_sel_o
);
  localparam int IDXW = $clog2(NUM_REGS + 1);

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_ADDR = 3'd1, PH_CMD = 3'd2,
    PH_CNT  = 3'd3, PH_DATA = 3'd4, PH_SKIP = 3'd5
  } phase_t;

  logic [2:0]            scl_sr, sda_sr;
  logic                  scl_now, scl_old, sda_now, sda_old;
  logic                  start_det, stop_det, scl_rise, scl_fall;
  phase_t                phase;
  logic [3:0]            bit_cnt;
  logic [7:0]            shreg;
  logic                  acking;
  logic [IDXW-1:0]       reg_idx;
  logic [NUM_REGS*8-1:0] ctrl_q;
  logic                  active, byte_done, addr_hit, wr_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end

  assign scl_now   = scl_sr[1];
  assign scl_old   = scl_sr[2];
  assign sda_now   = sda_sr[1];
  assign sda_old   = sda_sr[2];
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;

  assign active    = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign byte_done = active && scl_fall && !acking && (bit_cnt == 4'd8);
  assign addr_hit  = (shreg == {DEV_ADDR, 1'b0});
  assign wr_fire   = byte_done && (phase == PH_DATA) && (reg_idx < IDXW'(NUM_REGS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      acking     <= 1'b0;
      sda_pull_n <= 1'b1;
      reg_idx    <= '0;
    end else if (start_det) begin
      phase      <= PH_ADDR;
      bit_cnt    <= '0;
      acking     <= 1'b0;
      sda_pull_n <= 1'b1;
      reg_idx    <= '0;
    end else if (stop_det) begin
      phase      <= PH_IDLE;
      bit_cnt    <= '0;
      acking     <= 1'b0;
      sda_pull_n <= 1'b1;
    end else if (active) begin
      if (scl_rise && bit_cnt != 4'd8) begin
        shreg   <= {shreg[6:0], sda_now};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall && acking) begin
        acking     <= 1'b0;
        sda_pull_n <= 1'b1;
        bit_cnt    <= '0;
      end else if (byte_done) begin
        if (phase != PH_ADDR || addr_hit) begin
          acking     <= 1'b1;
          sda_pull_n <= 1'b0;
        end
        case (phase)
          PH_ADDR: phase <= addr_hit ? PH_CMD : PH_SKIP;
          PH_CMD:  phase <= PH_CNT;
          PH_CNT:  phase <= PH_DATA;
          default: if (wr_fire) reg_idx <= reg_idx + IDXW'(1);
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ctrl_q <= {NUM_REGS{REG_INIT}};
    else if (wr_fire)
      for (int k = 0; k < NUM_REGS; k++)
        if (reg_idx == IDXW'(k)) ctrl_q[k*8 +: 8] <= shreg;

  assign ctrl_o       = ctrl_q;
  assign spread_sel_o = ctrl_q[SPREAD_REG*8 + SPREAD_LSB +: 2];
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] REG_INIT = 8'hFF
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             sda_pull_n,
  input logic [NUM_REGS*8-1:0]            ctrl_o,
  input logic                             scl_fall,
  input logic                             start_det,
  input logic                             stop_det,
  input logic [2:0]                       phase,
  input logic [3:0]                       bit_cnt,
  input logic [$clog2(NUM_REGS+1)-1:0]    reg_idx
);
  localparam int IDXW = $clog2(NUM_REGS + 1);

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ctrl_o == {NUM_REGS{REG_INIT}}) && sda_pull_n);

  assert_ack_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_n) |-> $past(scl_fall));

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) |-> sda_pull_n);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx <= IDXW'(NUM_REGS));

  assert_commit_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(scl_fall && phase == 3'd4 && bit_cnt == 4'd8));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == 3'd1) && (bit_cnt == 4'd0) && (reg_idx == '0));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_n) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_n(sda_pull_n), .ctrl_o(ctrl_o),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .phase(phase), .bit_cnt(bit_cnt), .reg_idx(reg_idx)
);

// File: tb/i2c_cfg_slave_test.sv
`timescale 1ns/1ps
module i2c_cfg_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull_n;
  logic [31:0] ctrl_o;
  logic [1:0]  spread_sel_o;
  logic        sda_bus;

  assign sda_bus = sda_m & sda_pull_n;
  always #5 clk = ~clk;

  i2c_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_n(sda_pull_n), .ctrl_o(ctrl_o), .spread_sel_o(spread_sel_o)
  );

  string       tag_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  int          vectors = 0;
  int          errors  = 0;
  bit          finished = 0;
  logic [7:0]  model [4];
  logic [7:0]  payload[$];

  task automatic push(input string tag, input logic [31:0] e, input logic [31:0] a);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      string t;
      logic [31:0] e, a;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      a = act_q.pop_front();
      vectors++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #100;
    scl_m = 1'b1; #100;
    sda_m = 1'b0; #100;
    scl_m = 1'b0; #100;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #100;
    scl_m = 1'b1; #100;
    sda_m = 1'b1; #100;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic intact);
    intact = 1'b1;
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; #100;
      scl_m = 1'b1;   #100;
      if (sda_bus !== b[7-i]) intact = 1'b0;
      #100;
      scl_m = 1'b0;   #100;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic intact, ack;
    send_bits(b, 8, intact);
    sda_m = 1'b1; #100;
    scl_m = 1'b1; #100;
    ack = ~sda_bus;
    #100;
    scl_m = 1'b0; #100;
    push({tag, " ack"}, {31'd0, exp_ack}, {31'd0, ack});
    push("R10 data bits undisturbed", 32'd1, {31'd0, intact});
  endtask

  function automatic logic [31:0] model_word();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic check_regs(input string tag);
    #100;
    push(tag, model_word(), ctrl_o);
    push("R7 spread select", {30'd0, model[3][6:5]}, {30'd0, spread_sel_o});
    push("R10 released after stop", 32'd1, {31'd0, sda_pull_n});
  endtask

  task automatic send_preamble(input logic [7:0] cmd, input logic [7:0] cnt);
    send_byte(8'hD2, 1'b1, "R2 address 0xD2");
    send_byte(cmd, 1'b1, "R4 command byte");
    send_byte(cnt, 1'b1, "R4 count byte");
  endtask

  task automatic write_txn(input logic [7:0] cmd, input logic [7:0] cnt, input string tag);
    bus_start();
    send_preamble(cmd, cnt);
    foreach (payload[i]) begin
      send_byte(payload[i], 1'b1, (i < 4) ? "R5 data byte" : "R6 extra byte");
      if (i < 4) model[i] = payload[i];
    end
    bus_stop();
    check_regs(tag);
  endtask

  initial begin
    logic intact;
    for (int i = 0; i < 4; i++) model[i] = 8'hFF;
    #23; @(negedge clk); rst_n = 1'b1;
    #100;
    push("R1 reset ctrl", 32'hFFFF_FFFF, ctrl_o);
    push("R1 reset spread", 32'd3, {30'd0, spread_sel_o});
    push("R1 reset sda released", 32'd1, {31'd0, sda_pull_n});

    payload = '{8'h12, 8'h34, 8'h56, 8'h40};
    write_txn(8'h00, 8'h04, "R5 full fill");

    payload = '{8'hA5};
    write_txn(8'hFF, 8'h01, "R5 R4 partial fill touches reg0 only");

    payload = '{8'h01, 8'h02, 8'h03, 8'h20, 8'hEE, 8'hDD};
    write_txn(8'h12, 8'h34, "R6 extra bytes discarded");

    bus_start();
    send_byte(8'hD4, 1'b0, "R3 wrong address");
    send_byte(8'h55, 1'b0, "R3 ignored after mismatch");
    send_byte(8'h66, 1'b0, "R3 ignored after mismatch");
    bus_stop();
    check_regs("R3 regs after wrong address");

    bus_start();
    send_byte(8'hD3, 1'b0, "R3 read request");
    send_byte(8'h00, 1'b0, "R3 ignored after read");
    bus_stop();
    check_regs("R3 regs after read request");

    bus_start();
    send_preamble(8'h00, 8'h00);
    send_byte(8'h9C, 1'b1, "R5 data byte");
    model[0] = 8'h9C;
    send_bits(8'hF0, 4, intact);
    bus_stop();
    check_regs("R8 stop mid-byte keeps regs");

    bus_start();
    send_byte(8'hD2, 1'b1, "R2 address 0xD2");
    send_byte(8'h00, 1'b1, "R4 command byte");
    send_bits(8'h0F, 5, intact);
    bus_stop();
    check_regs("R8 stop inside count byte");

    bus_start();
    send_preamble(8'h00, 8'h00);
    send_byte(8'h66, 1'b1, "R5 data byte");
    model[0] = 8'h66;
    bus_start();
    send_preamble(8'h00, 8'h00);
    send_byte(8'h77, 1'b1, "R9 data after restart");
    send_byte(8'h88, 1'b1, "R9 data after restart");
    model[0] = 8'h77;
    model[1] = 8'h88;
    bus_stop();
    check_regs("R9 repeated start rewinds to reg0");

    bus_start();
    send_byte(8'hD2, 1'b1, "R2 address 0xD2");
    bus_start();
    send_byte(8'hA2, 1'b0, "R9 R3 address checked again after restart");
    send_byte(8'h11, 1'b0, "R3 ignored after mismatch");
    bus_stop();
    check_regs("R9 regs after restart mismatch");

    #200;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule